// File: doc/BRIEF.md
# DMA Channel Request Sequencer

This block runs the request side of one DMA channel. Software programs a control word and a byte count. The block then decides when the transfer engine may start each source-to-destination move. It lowers the count as moves complete and raises a sticky completion flag once the count is used up. The bus data path itself sits outside, in a separate transfer engine. The sequencer offers each move on a valid/ready launch port, and the engine reports the end of each move with a one-cycle `xfer_done` strobe.

Each run starts from one request. A request comes either from software, through a start bit in the control word, or from a peripheral, through a request strobe. A mode bit selects the run length. In cycle-steal mode, each request yields exactly one move. In continuous mode, one request yields moves back to back until the count reaches zero. A nonzero bandwidth field in continuous mode adds a fixed idle gap after every block of moves. Writing one to the completion bit clears it and also stops any run in progress.

The block also holds an 8-bit interrupt vector. It drives the vector onto `data_out` during an interrupt-acknowledge cycle.

Top module: `dma_req_seq`

## Requirements
- R1: After reset, the block is idle with `xfer_valid`, `busy`, `done` and `start_flag` all low, `byte_count` is 0, and the vector register holds `VEC_RST` (default 8'h0F).
- R2: The control word is decoded from fixed bit positions. Bit 29 set selects cycle-steal mode and bit 29 clear selects continuous mode. Bit 30 set selects the peripheral as the request source and bit 30 clear selects software. Bit 16 is the start bit. Bits 27:25 hold the bandwidth field.
- R3: A control write with bit 16 = 1 and bit 30 = 0 sets `start_flag`. A control write with bit 16 = 0 leaves `start_flag` unchanged. A control write with bit 30 = 1 clears `start_flag`. `start_flag` clears once its request is taken. A request taken while `byte_count` is 0 or `done` is 1 is discarded and launches no move.
- R4: When bit 30 is set, a `periph_req` pulse is held pending, even one that arrives while a move is busy. The pending request is served once the channel returns to idle. When bit 30 is clear, `periph_req` is ignored.
- R5: `xfer_valid` stays high until `xfer_ready` accepts the move. Only an abort can lower it earlier. Each acceptance is one move, and that move ends on the next `xfer_done`.
- R6: In cycle-steal mode, one request yields exactly one move, after which the channel returns to idle.
- R7: In continuous mode with a bandwidth field of 000, the next move is offered in the cycle right after the previous one completes. Moves continue until the count reaches zero. With the engine always ready and completing one cycle after acceptance, moves are accepted every 2 cycles.
- R8: In continuous mode with a nonzero bandwidth field, the channel inserts `GAP_CYC` idle cycles before offering the next move. This happens after every `BLK_XFERS` completed moves, unless the count has reached zero.
- R9: Each completed move lowers `byte_count` by `XFER_BYTES`, saturating at 0. A count write takes effect only while the channel is idle and is ignored during a run.
- R10: `done` sets on the completion that brings the count to zero, and it stays set until it is cleared.
- R11: A status write with `stat_w1c` = 1 clears `done`, ends any run, and drops all pending requests. If it lands in the same cycle as a completion, the clear wins. A status write with `stat_w1c` = 0 has no effect. An `xfer_done` that arrives while the channel is idle is ignored.
- R12: `data_out` equals the vector register while `iack` is high and 0 otherwise. A `vec_wr` loads the vector register from `vec_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word |
| cnt_wr | input | 1 | Byte count write strobe |
| cnt_wdata | input | CNT_W | Byte count value |
| stat_wr | input | 1 | Status write strobe |
| stat_w1c | input | 1 | Written value of the completion bit (1 clears and aborts) |
| periph_req | input | 1 | Peripheral request strobe |
| xfer_valid | output | 1 | A move is offered to the engine |
| xfer_ready | input | 1 | Engine accepts the offered move |
| xfer_done | input | 1 | Engine finished the accepted move |
| iack | input | 1 | Interrupt-acknowledge cycle |
| vec_wr | input | 1 | Vector register write strobe |
| vec_wdata | input | 8 | Vector value |
| data_out | output | 8 | Vector during acknowledge, else 0 |
| busy | output | 1 | Channel is in a run |
| done | output | 1 | Completion flag |
| start_flag | output | 1 | Software start request pending |
| byte_count | output | CNT_W | Remaining byte count |

## Verification
The bench builds the block with an 8-bit count, 2-byte moves, blocks of 2 moves and a 3-cycle gap. This keeps every run short enough to sweep starting counts 1 to 9 against three bandwidth settings. That sweep brings both odd-count saturation and gap placement at every block boundary within reach. The bench computes the expected move count and the spacing between moves arithmetically from those parameters. Short cycle-steal, peripheral and abort scenarios cover the pending-request and clear-wins corners.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  localparam int START_POS = 16;
  localparam int BW_LSB    = 25;
  localparam int BW_MSB    = 27;
  localparam int STEAL_POS = 29;
  localparam int SRC_POS   = 30;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2,
    SQ_GAP   = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic       steal;
    logic       periph;
    logic [2:0] bw;
  } chan_cfg_t;
endpackage

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_req_pkg::*;
#(
  parameter logic [7:0] VEC_RST = 8'h0F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_wr,
  input  logic [31:0] ctrl_wdata,
  input  logic        periph_req,
  input  logic        take_req,
  input  logic        flush,
  input  logic        vec_wr,
  input  logic [7:0]  vec_wdata,
  input  logic        iack,
  output chan_cfg_t   cfg,
  output logic        start_q,
  output logic        pend_q,
  output logic [7:0]  data_out
);
  logic [7:0] vec_q;
  logic       wr_start;
  logic       wr_periph;

  assign wr_start  = ctrl_wr && ctrl_wdata[START_POS] && !ctrl_wdata[SRC_POS];
  assign wr_periph = ctrl_wr && ctrl_wdata[SRC_POS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (ctrl_wr) begin
      cfg.steal  <= ctrl_wdata[STEAL_POS];
      cfg.periph <= ctrl_wdata[SRC_POS];
      cfg.bw     <= ctrl_wdata[BW_MSB:BW_LSB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          start_q <= 1'b0;
    else if (flush)      start_q <= 1'b0;
    else if (wr_start)   start_q <= 1'b1;
    else if (wr_periph)  start_q <= 1'b0;
    else if (take_req)   start_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pend_q <= 1'b0;
    else if (flush)                  pend_q <= 1'b0;
    else if (ctrl_wr && !ctrl_wdata[SRC_POS]) pend_q <= 1'b0;
    else if (periph_req && cfg.periph) pend_q <= 1'b1;
    else if (take_req)               pend_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= VEC_RST;
    else if (vec_wr) vec_q <= vec_wdata;
  end

  assign data_out = iack ? vec_q : 8'h00;

  a_r3_start_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && !ctrl_wr) |=> !start_q);
endmodule

// File: rtl/dma_byte_counter.sv
module dma_byte_counter #(
  parameter int CNT_W      = 16,
  parameter int XFER_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             next_zero,
  output logic             nonzero
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(XFER_BYTES);

  logic [CNT_W-1:0] cnt_less;

  assign cnt_less  = (count <= STEP) ? '0 : count - STEP;
  assign next_zero = (cnt_less == '0);
  assign nonzero   = (count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (load)  count <= load_val;
    else if (dec)   count <= cnt_less;
  end

  a_r9_never_grows: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (count <= $past(count)));
endmodule

// File: rtl/dma_pace_timer.sv
module dma_pace_timer #(
  parameter int BLK_XFERS = 4,
  parameter int GAP_CYC   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_start,
  input  logic xfer_cmp,
  input  logic gap_load,
  input  logic gap_tick,
  output logic block_end,
  output logic gap_over
);
  localparam int BLK_W = (BLK_XFERS > 1) ? $clog2(BLK_XFERS) : 1;
  localparam int GAP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLK_XFERS - 1);
  localparam logic [GAP_W-1:0] GAP_INIT = GAP_W'(GAP_CYC - 1);

  logic [BLK_W-1:0] blk_cnt;
  logic [GAP_W-1:0] gap_cnt;

  assign block_end = (blk_cnt == BLK_LAST);
  assign gap_over  = (gap_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         blk_cnt <= '0;
    else if (run_start) blk_cnt <= '0;
    else if (xfer_cmp)  blk_cnt <= block_end ? '0 : blk_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     gap_cnt <= '0;
    else if (gap_load)              gap_cnt <= GAP_INIT;
    else if (gap_tick && !gap_over) gap_cnt <= gap_cnt - 1'b1;
  end

  a_r8_block_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_cmp && !run_start && !block_end) |=> (blk_cnt == $past(blk_cnt) + 1'b1));
endmodule

// File: rtl/dma_req_seq.sv
module dma_req_seq
  import dma_req_pkg::*;
#(
  parameter int         CNT_W      = 16,
  parameter int         XFER_BYTES = 4,
  parameter int         BLK_XFERS  = 4,
  parameter int         GAP_CYC    = 8,
  parameter logic [7:0] VEC_RST    = 8'h0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [31:0]      ctrl_wdata,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             stat_wr,
  input  logic             stat_w1c,
  input  logic             periph_req,
  output logic             xfer_valid,
  input  logic             xfer_ready,
  input  logic             xfer_done,
  input  logic             iack,
  input  logic             vec_wr,
  input  logic [7:0]       vec_wdata,
  output logic [7:0]       data_out,
  output logic             busy,
  output logic             done,
  output logic             start_flag,
  output logic [CNT_W-1:0] byte_count
);
  seq_state_t state_q, state_d;
  chan_cfg_t  cfg;
  logic start_q, pend_q, req_any, take_req, launch, abort;
  logic cmp, next_zero, nonzero, block_end, gap_over, gap_load;

  assign abort    = stat_wr && stat_w1c;
  assign req_any  = cfg.periph ? pend_q : start_q;
  assign take_req = (state_q == SQ_IDLE) && req_any && !abort;
  assign launch   = take_req && nonzero && !done;
  assign cmp      = (state_q == SQ_WAIT) && xfer_done;
  assign gap_load = cmp && !abort && !next_zero && !cfg.steal &&
                    (cfg.bw != 3'b000) && block_end;

  dma_ctrl_regs #(.VEC_RST(VEC_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .periph_req(periph_req), .take_req(take_req), .flush(abort),
    .vec_wr(vec_wr), .vec_wdata(vec_wdata), .iack(iack),
    .cfg(cfg), .start_q(start_q), .pend_q(pend_q), .data_out(data_out)
  );

  dma_byte_counter #(.CNT_W(CNT_W), .XFER_BYTES(XFER_BYTES)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .load(cnt_wr && (state_q == SQ_IDLE)), .load_val(cnt_wdata),
    .dec(cmp), .count(byte_count), .next_zero(next_zero), .nonzero(nonzero)
  );

  dma_pace_timer #(.BLK_XFERS(BLK_XFERS), .GAP_CYC(GAP_CYC)) u_pace (
    .clk(clk), .rst_n(rst_n), .run_start(launch), .xfer_cmp(cmp),
    .gap_load(gap_load), .gap_tick(state_q == SQ_GAP),
    .block_end(block_end), .gap_over(gap_over)
  );

  always_comb begin
    state_d = state_q;
    if (abort) begin
      state_d = SQ_IDLE;
    end else begin
      unique case (state_q)
        SQ_IDLE:  if (launch) state_d = SQ_ISSUE;
        SQ_ISSUE: if (xfer_ready) state_d = SQ_WAIT;
        SQ_WAIT: begin
          if (xfer_done) begin
            if (next_zero || cfg.steal) state_d = SQ_IDLE;
            else if (gap_load)          state_d = SQ_GAP;
            else                        state_d = SQ_ISSUE;
          end
        end
        SQ_GAP:   if (gap_over) state_d = SQ_ISSUE;
        default:  state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 done <= 1'b0;
    else if (abort)             done <= 1'b0;
    else if (cmp && next_zero)  done <= 1'b1;
  end

  assign xfer_valid = (state_q == SQ_ISSUE);
  assign busy       = (state_q != SQ_IDLE);
  assign start_flag = start_q;

  a_r5_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready && !abort) |=> xfer_valid);
  a_r10_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (byte_count == '0));
  a_r6_steal_one_move: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp && cfg.steal) |=> !xfer_valid);
  a_r11_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !done));
endmodule

// File: tb/sim_dma_req_seq.sv
module sim_dma_req_seq;
  localparam int CW = 8, XB = 2, BLK = 2, GAP = 3;

  logic clk = 0, rst_n = 0;
  logic ctrl_wr = 0, cnt_wr = 0, stat_wr = 0, stat_w1c = 0, periph_req = 0;
  logic [31:0] ctrl_wdata = 0;
  logic [CW-1:0] cnt_wdata = 0;
  logic xfer_ready = 1, xfer_done = 0, iack = 0, vec_wr = 0;
  logic [7:0] vec_wdata = 0, data_out;
  logic xfer_valid, busy, done, start_flag;
  logic [CW-1:0] byte_count;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int hs_total = 0, last_cyc = 0, iv_base = 0, iv_bw = 0;
  bit iv_on = 0, pend = 0;

  dma_req_seq #(.CNT_W(CW), .XFER_BYTES(XB), .BLK_XFERS(BLK), .GAP_CYC(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .stat_wr(stat_wr), .stat_w1c(stat_w1c),
    .periph_req(periph_req), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_done(xfer_done), .iack(iack), .vec_wr(vec_wr), .vec_wdata(vec_wdata),
    .data_out(data_out), .busy(busy), .done(done), .start_flag(start_flag),
    .byte_count(byte_count)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // transfer engine model and launch spacing monitor
  always @(negedge clk) begin
    xfer_done <= pend;
    pend <= xfer_valid && xfer_ready;
    if (xfer_valid && xfer_ready) begin
      int idx;
      hs_total = hs_total + 1;
      idx = hs_total - iv_base;
      if (iv_on && idx > 1)
        check((iv_bw != 0) ? "R8 spacing" : "R7 spacing", cyc - last_cyc,
              2 + (((iv_bw != 0) && ((idx - 1) % BLK == 0)) ? GAP : 0));
      last_cyc = cyc;
    end
  end

  task automatic wr_ctrl(input bit steal, input bit src, input bit st, input int bw);
    @(negedge clk);
    ctrl_wdata = 0;
    ctrl_wdata[29] = steal; ctrl_wdata[30] = src; ctrl_wdata[16] = st;
    ctrl_wdata[27:25] = 3'(bw);
    ctrl_wr = 1;
    @(negedge clk); ctrl_wr = 0;
  endtask
  task automatic wr_cnt(input int v);
    @(negedge clk); cnt_wdata = CW'(v); cnt_wr = 1;
    @(negedge clk); cnt_wr = 0;
  endtask
  task automatic wr_stat(input bit b);
    @(negedge clk); stat_w1c = b; stat_wr = 1;
    @(negedge clk); stat_wr = 0;
  endtask
  task automatic pulse_periph();
    @(negedge clk); periph_req = 1;
    @(negedge clk); periph_req = 0;
  endtask
  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int g = 0; g < 3000 && busy; g++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", xfer_valid, 0); check("R1 busy", busy, 0);
    check("R1 done", done, 0); check("R1 start", start_flag, 0);
    check("R1 count", byte_count, 0);
    rst_n = 1;
    @(negedge clk);
    check("R12 no iack", data_out, 0);
    iack = 1; #1; check("R1 R12 vector reset", data_out, 8'h0F);
    iack = 0;
    @(negedge clk); vec_wr = 1; vec_wdata = 8'hA5;
    @(negedge clk); vec_wr = 0; iack = 1; #1;
    check("R12 vector load", data_out, 8'hA5); iack = 0;

    // R2 R7 R8 R9 R10 continuous sweep over counts and bandwidth codes
    for (int b = 0; b < 3; b++) begin
      for (int c = 1; c <= 9; c++) begin
        int bw;
        bw = (b == 0) ? 0 : (b == 1) ? 1 : 4;
        wr_stat(1); wr_cnt(c);
        iv_base = hs_total; iv_bw = bw; iv_on = 1;
        wr_ctrl(0, 0, 1, bw);
        wait_idle();
        iv_on = 0;
        check("R7 R9 move count", hs_total - iv_base, (c + XB - 1) / XB);
        check("R9 count zero", byte_count, 0);
        check("R10 done", done, 1);
        check("R3 start cleared", start_flag, 0);
      end
    end

    // R11 writing zero leaves done
    wr_stat(0);
    check("R11 zero write", done, 1);
    // R3 request discarded while done is set
    wr_cnt(6); h0 = hs_total;
    wr_ctrl(1, 0, 1, 0); wait_idle();
    check("R3 discard done", hs_total - h0, 0);
    check("R3 discard start", start_flag, 0);
    // R3 discard with count zero
    wr_stat(1); wr_cnt(0); h0 = hs_total;
    wr_ctrl(1, 0, 1, 0); wait_idle();
    check("R3 discard zero", hs_total - h0, 0);

    // R5 R6 R9 cycle steal, software source
    wr_cnt(5);
    xfer_ready = 0; h0 = hs_total;
    wr_ctrl(1, 0, 1, 0);
    repeat (5) @(negedge clk);
    check("R5 valid held", xfer_valid, 1);
    check("R3 start taken", start_flag, 0);
    xfer_ready = 1; wait_idle();
    check("R6 one move", hs_total - h0, 1);
    check("R9 count 5-2", byte_count, 3);
    wr_ctrl(1, 0, 1, 0); wait_idle();
    check("R6 second", hs_total - h0, 2);
    check("R9 count 3-2", byte_count, 1);
    check("R10 not yet", done, 0);
    wr_ctrl(1, 0, 1, 0); wait_idle();
    check("R9 saturate", byte_count, 0);
    check("R10 done steal", done, 1);

    // R4 peripheral requests
    wr_stat(1); wr_cnt(20);
    wr_ctrl(1, 1, 1, 0);
    check("R3 start with periph src", start_flag, 0);
    h0 = hs_total;
    pulse_periph(); wait_idle();
    check("R4 one periph move", hs_total - h0, 1);
    h0 = hs_total;
    pulse_periph(); @(negedge clk);
    check("R4 busy", busy, 1);
    pulse_periph(); wait_idle();
    check("R4 pending served", hs_total - h0, 2);
    check("R9 count 20-6", byte_count, 14);
    wr_ctrl(1, 0, 0, 0); h0 = hs_total;
    pulse_periph(); wait_idle();
    check("R4 ignored", hs_total - h0, 0);

    // R11 abort of continuous run
    wr_cnt(200);
    wr_ctrl(0, 0, 1, 0);
    repeat (10) @(negedge clk);
    wr_stat(1);
    h0 = hs_total;
    repeat (30) @(negedge clk);
    check("R11 no moves after", hs_total - h0, 0);
    check("R11 idle", busy, 0);
    check("R11 done clear", done, 0);
    check("R11 partial", (byte_count > 0 && byte_count < 200) ? 1 : 0, 1);

    // R9 count write ignored during a run
    wr_cnt(100);
    wr_ctrl(0, 0, 1, 1);
    repeat (6) @(negedge clk);
    wr_cnt(3);
    repeat (4) @(negedge clk);
    wr_stat(1); repeat (4) @(negedge clk);
    check("R9 load ignored", (byte_count > 3 && byte_count[0] == 1'b0) ? 1 : 0, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule